// File: doc/BRIEF.md
# Three-Way Compare Unit

This unit compares two operands and returns a 32-bit ordering code: zero when they are equal, plus one when the second operand is the larger, and minus one (all ones) when the first operand is the larger. A 3-bit mode selects how the 64-bit operand buses are read. They can be read as single-precision IEEE 754 patterns in the low 32 bits, as double-precision patterns, or as signed 64-bit integers.

The float modes come in two flavours per precision. They differ only when an operand is not a number (NaN). One flavour then reports minus one and the other reports plus one, so software can pick the flavour that makes its intended test fail safely. There is no separate unordered flag. The unit takes a request on a valid strobe and presents a registered result one clock later. The result then holds until the next request.

Top module: `cmp3_unit`

## Requirements
- R1: The result only ever takes one of three values: 0x00000000 (equal), 0x00000001 (second operand larger) or 0xFFFFFFFF (first operand larger).
- R2: Mode 4 compares `opnd_a` and `opnd_b` as signed two's-complement 64-bit integers.
- R3: Modes 0 and 1 compare the low 32 bits of each operand as single-precision values, and bits 63:32 have no effect on the result.
- R4: Modes 2 and 3 compare the full 64 bits as double-precision values. Both float widths order finite values, subnormals and infinities by numeric value.
- R5: In every float mode, positive zero and negative zero compare as equal (result 0).
- R6: In modes 0 and 2, a NaN in either operand gives 0xFFFFFFFF. A NaN is an exponent of all ones with a nonzero fraction, in either sign.
- R7: In modes 1 and 3, a NaN in either operand gives 0x00000001.
- R8: Modes 5, 6 and 7 give a result of 0 whatever the operands.
- R9: After reset, `out_valid` is 0 and `result` is 0.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` is updated only on those requests and holds its value while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands and mode are sampled when high |
| mode | input | 3 | 0 single/low-bias, 1 single/high-bias, 2 double/low-bias, 3 double/high-bias, 4 signed long |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Ordering code 0, 1 or 0xFFFFFFFF |

## Verification
The bench targets the following corner cases:
- Signed-zero pairs: a design that compares raw bit patterns reports the two zeros as unequal.
- Negative-versus-negative float pairs: a design that treats the sign as an ordinary magnitude bit returns the reversed order for these.
- NaNs with either sign and with only the lowest fraction bit set: a design that checks only the quiet bit, or only one operand, lets these fall through to an ordered result.
- Infinity against NaN: these catch an exponent-only NaN test.
- Single-precision vectors always carry random upper halves, so a design that reads the wrong bits shows a random result.
- Integers that straddle zero: these expose a design that compares them unsigned.

// File: rtl/cmp3_unit.sv
module cmp3_unit #(
  parameter int W  = 64,
  parameter int SW = 32,
  parameter int SE = 8,
  parameter int DE = 11,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    mode,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  output logic          out_valid,
  output logic [RW-1:0] result
);
  localparam int SM = SW - SE - 1;
  localparam int DM = W - DE - 1;
  localparam logic [RW-1:0] RES_EQ  = '0;
  localparam logic [RW-1:0] RES_POS = RW'(1);
  localparam logic [RW-1:0] RES_NEG = '1;
  localparam logic [2:0] M_SGL_LO = 3'd0;
  localparam logic [2:0] M_SGL_HI = 3'd1;
  localparam logic [2:0] M_DBL_LO = 3'd2;
  localparam logic [2:0] M_DBL_HI = 3'd3;
  localparam logic [2:0] M_LONG   = 3'd4;

  logic [SW-1:0] sa, sb, skey_a, skey_b;
  logic [W-1:0]  dkey_a, dkey_b;
  logic          s_nan, d_nan, s_zero, d_zero;
  logic [RW-1:0] s_ord, d_ord, l_ord, nxt;

  assign sa = opnd_a[SW-1:0];
  assign sb = opnd_b[SW-1:0];

  assign s_nan = (&sa[SW-2:SM] && |sa[SM-1:0]) || (&sb[SW-2:SM] && |sb[SM-1:0]);
  assign d_nan = (&opnd_a[W-2:DM] && |opnd_a[DM-1:0]) ||
                 (&opnd_b[W-2:DM] && |opnd_b[DM-1:0]);

  assign s_zero = ~|sa[SW-2:0] && ~|sb[SW-2:0];
  assign d_zero = ~|opnd_a[W-2:0] && ~|opnd_b[W-2:0];

  assign skey_a = sa[SW-1] ? ~sa : {1'b1, sa[SW-2:0]};
  assign skey_b = sb[SW-1] ? ~sb : {1'b1, sb[SW-2:0]};
  assign dkey_a = opnd_a[W-1] ? ~opnd_a : {1'b1, opnd_a[W-2:0]};
  assign dkey_b = opnd_b[W-1] ? ~opnd_b : {1'b1, opnd_b[W-2:0]};

  assign s_ord = (s_zero || skey_a == skey_b) ? RES_EQ :
                 (skey_a < skey_b) ? RES_POS : RES_NEG;
  assign d_ord = (d_zero || dkey_a == dkey_b) ? RES_EQ :
                 (dkey_a < dkey_b) ? RES_POS : RES_NEG;
  assign l_ord = (opnd_a == opnd_b) ? RES_EQ :
                 ($signed(opnd_a) < $signed(opnd_b)) ? RES_POS : RES_NEG;

  always_comb begin
    unique case (mode)
      M_SGL_LO: nxt = s_nan ? RES_NEG : s_ord;
      M_SGL_HI: nxt = s_nan ? RES_POS : s_ord;
      M_DBL_LO: nxt = d_nan ? RES_NEG : d_ord;
      M_DBL_HI: nxt = d_nan ? RES_POS : d_ord;
      M_LONG:   nxt = l_ord;
      default:  nxt = RES_EQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= RES_EQ;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/cmp3_unit_chk.sv
module cmp3_unit_chk #(
  parameter int W  = 64,
  parameter int SW = 32,
  parameter int SE = 8,
  parameter int DE = 11,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    mode,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b,
  input logic          out_valid,
  input logic [RW-1:0] result
);
  localparam int SM = SW - SE - 1;
  localparam int DM = W - DE - 1;
  logic s_nan_a, d_nan_b;
  assign s_nan_a = &opnd_a[SW-2:SM] && |opnd_a[SM-1:0];
  assign d_nan_b = &opnd_b[W-2:DM] && |opnd_b[DM-1:0];

  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result == '0 || result == RW'(1) || result == '1)); // R1
  AST_LONG_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd4 && opnd_a == opnd_b) |=> result == '0); // R2
  AST_DBL_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd2 && opnd_a[W-2:0] == '0 && opnd_b[W-2:0] == '0) |=> result == '0); // R5
  AST_SGL_NAN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd0 && s_nan_a) |=> result == '1); // R6
  AST_DBL_NAN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd3 && d_nan_b) |=> result == RW'(1)); // R7
  AST_SPARE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode > 3'd4) |=> result == '0); // R8
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result))); // R10
endmodule

bind cmp3_unit cmp3_unit_chk #(.W(W), .SW(SW), .SE(SE), .DE(DE), .RW(RW)) u_chk (.*);

// File: tb/sim_cmp3_unit.sv
module sim_cmp3_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid;
  logic [31:0] result;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cmp3_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
                .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

  function automatic real s2r(input logic [31:0] x);
    real v;
    int  e;
    e = int'(x[30:23]);
    if (e == 255) v = 1.0e40;
    else if (e == 0) v = real'(x[22:0]) * (2.0 ** (-149));
    else v = real'(int'(x[22:0]) + 8388608) * (2.0 ** (e - 150));
    return x[31] ? -v : v;
  endfunction

  function automatic logic [31:0] ord(input real a, input real b);
    if (a == b) return 32'h0;
    return (b > a) ? 32'h1 : 32'hFFFFFFFF;
  endfunction

  function automatic logic [31:0] expect_of(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
    logic sn, dn;
    sn = (a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0);
    dn = (a[62:52] == 11'h7FF && a[51:0] != 0) || (b[62:52] == 11'h7FF && b[51:0] != 0);
    case (m)
      3'd0: return sn ? 32'hFFFFFFFF : ord(s2r(a[31:0]), s2r(b[31:0]));
      3'd1: return sn ? 32'h1 : ord(s2r(a[31:0]), s2r(b[31:0]));
      3'd2: return dn ? 32'hFFFFFFFF : ord($bitstoreal(a), $bitstoreal(b));
      3'd3: return dn ? 32'h1 : ord($bitstoreal(a), $bitstoreal(b));
      3'd4: return (a == b) ? 32'h0 : ($signed(a) < $signed(b)) ? 32'h1 : 32'hFFFFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pick_s();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h80000000;
      2: return 32'h7F800000;
      3: return 32'hFF800000;
      4: return {r[31], 8'hFF, r[22:0] | 23'h1};
      5: return {r[31], 8'h00, r[22:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [63:0] pick_d();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 8)
      0: return 64'h0;
      1: return 64'h8000000000000000;
      2: return 64'h7FF0000000000000;
      3: return 64'hFFF0000000000000;
      4: return {r[63], 11'h7FF, r[51:0] | 52'h1};
      5: return {r[63], 11'h000, r[51:0]};
      default: return r;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] e;
    e = expect_of(m, a, b);
    @(negedge clk);
    in_valid = 1'b1; mode = m; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'h0, out_valid}, 32'h1);
    check(tag, result, e);
  endtask

  function automatic string tag_of(input logic [2:0] m, input logic [31:0] e);
    if (m > 3'd4) return "R8";
    if (m == 3'd4) return "R2";
    if (m[0] && e == 32'h1) return "R7/R4";
    if (!m[0] && e == 32'hFFFFFFFF) return "R6/R4";
    return m[1] ? "R4" : "R3";
  endfunction

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    #1;
    check("R9 reset valid", {31'h0, out_valid}, 32'h0);
    check("R9 reset result", result, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    apply("R3 1<2", 3'd0, {32'hDEADBEEF, 32'h3F800000}, {32'h12345678, 32'h40000000});
    apply("R3 -1 vs -2", 3'd1, {32'hFFFFFFFF, 32'hBF800000}, {32'h0, 32'hC0000000});
    apply("R5 single zeros", 3'd0, 64'h80000000, 64'h0);
    apply("R5 double zeros", 3'd3, 64'h0, 64'h8000000000000000);
    apply("R4 -inf<1", 3'd2, 64'hFFF0000000000000, 64'h3FF0000000000000);
    apply("R4 inf=inf", 3'd1, 64'h7F800000, 64'h7F800000);
    apply("R4 subnormal", 3'd0, 64'h00000001, 64'h0);
    apply("R6 single nan b", 3'd0, 64'h3F800000, 64'h7FC00000);
    apply("R7 single nan a", 3'd1, 64'hFF800001, 64'h3F800000);
    apply("R6 double snan", 3'd2, 64'h7FF0000000000001, 64'h7FF0000000000000);
    apply("R7 double neg nan", 3'd3, 64'h0, 64'hFFF8000000000000);
    apply("R6 nan=nan", 3'd0, 64'h7FC00000, 64'h7FC00000);
    apply("R2 -1<1", 3'd4, 64'hFFFFFFFFFFFFFFFF, 64'h1);
    apply("R2 max>min", 3'd4, 64'h7FFFFFFFFFFFFFFF, 64'h8000000000000000);
    apply("R2 equal", 3'd4, 64'h123456789, 64'h123456789);
    apply("R8 mode5", 3'd5, 64'h1, 64'h2);
    apply("R8 mode7", 3'd7, 64'h7FF8000000000000, 64'h0);
    apply("R1 set nonzero", 3'd4, 64'h5, 64'h2);
    held = result;
    @(negedge clk);
    mode = 3'd4; opnd_a = 64'h0; opnd_b = 64'h9;
    @(negedge clk);
    check("R10 no valid", {31'h0, out_valid}, 32'h0);
    check("R10 hold", result, held);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  m;
      logic [63:0] a, b;
      logic [31:0] e;
      m = 3'($urandom % 8);
      if (m < 3'd2) begin
        a = {$urandom, pick_s()};
        b = ($urandom % 5 == 0) ? {$urandom, a[31:0]} : {$urandom, pick_s()};
      end else if (m < 3'd4) begin
        a = pick_d();
        b = ($urandom % 5 == 0) ? a : pick_d();
      end else begin
        a = {$urandom, $urandom};
        b = ($urandom % 5 == 0) ? a : {$urandom, $urandom};
      end
      e = expect_of(m, a, b);
      apply(tag_of(m, e), m, a, b);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule